// File: doc/BRIEF.md
# DRAM Strobe Decoder with Write-Mode Detection

This block is the device-side control of an asynchronous-strobe DRAM, rebuilt as synchronous logic. It samples the active-low row strobe, column strobe, write enable and output enable through two-flop synchronisers. It finds edges on the synchronised levels and sorts every memory cycle into one of these kinds: read, early write, late write, RAS-only refresh, CAS-before-RAS refresh, hidden refresh or test-mode entry.

The block holds the row address taken when the row strobe falls and the column address taken when the column strobe falls. It drives a plain array port: row, column, write strobe, write data and combinational read data. It also keeps an internal refresh row counter for the refresh kinds that take no address. It controls when read data is driven and when write data is captured, and it reports each refresh with a one-cycle pulse and the refreshed row.

Strobe, address and data inputs may change at any time. Address and data must stay stable for at least four clocks around each strobe change. The block acts on a strobe change at the third rising clock edge after it.

Top module: `dram_strobe_ctl`

## Requirements
- R1: After synchronous reset: dq_oe=0, arr_we=0, refresh_valid=0, oe_err=0, test_mode=0, refresh_row=0 and cyc_kind=0 (idle).
- R2: A row strobe fall with the column strobe high latches addr as the row. A later column strobe fall with write enable high latches addr as the column and reads the array. While both the column strobe and output enable stay low, dq_oe=1 and dq_out holds the word read. cyc_kind=1 (read).
- R3: If write enable is already low when the column strobe falls, din is written at the latched row and column and cyc_kind=2 (early write). dq_oe stays 0 for the whole column cycle.
- R4: If write enable falls while the column strobe is low after a read, and output enable is high, din is written at that edge and cyc_kind=3 (late write). dq_out keeps the earlier read word, and it is driven again if output enable returns low while the column strobe stays low.
- R5: If a late write is attempted while output enable is low, no array write takes place, oe_err pulses for one cycle, and cyc_kind keeps its previous value.
- R6: dq_oe is 0 whenever the synchronised column strobe or output enable is high.
- R7: With the row strobe held low, each further column strobe cycle accesses a new column in the same row.
- R8: A row strobe cycle in which the column strobe never falls pulses refresh_valid with refresh_row equal to the latched row, sets cyc_kind=4 (RAS-only), and leaves dq_oe at 0.
- R9: A row strobe fall while the column strobe is low pulses refresh_valid with refresh_row equal to the internal counter. The counter then advances by one modulo 2^AW, starting from 0 after reset. With write enable high and no read data held, cyc_kind=5.
- R10: If the column strobe stays low after a read while the row strobe rises and falls again, the cycle is a counter refresh with cyc_kind=6 (hidden), and dq_out keeps driving the earlier read word.
- R11: A counter refresh with write enable low sets test_mode and cyc_kind=7, and it also refreshes and advances the counter. test_mode stays set through further such cycles. It clears only on a RAS-only refresh or on a counter refresh with write enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| cas_n | input | 1 | Column strobe, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | AW | Multiplexed row/column address |
| din | input | DW | Write data |
| dq_out | output | DW | Read data toward the pins |
| dq_oe | output | 1 | Drive enable for dq_out |
| arr_row | output | AW | Array row address |
| arr_col | output | AW | Array column address |
| arr_we | output | 1 | Array write strobe, one cycle |
| arr_wdata | output | DW | Array write data |
| arr_rdata | input | DW | Array read data, combinational from arr_row/arr_col |
| refresh_valid | output | 1 | One-cycle pulse per refresh |
| refresh_row | output | AW | Row refreshed by the last pulse |
| test_mode | output | 1 | Test mode active |
| cyc_kind | output | 3 | Kind of the last classified cycle |
| oe_err | output | 1 | Pulse: late write refused because output enable was low |

## Verification
The bench targets how write enable is ordered against the column strobe. If early and late writes were swapped, the early write would drive data or the late write would lose its read word. A late write with output enable low is read back afterwards: a design that still wrote would show the new word. The hidden refresh checks that the output keeps driving across the row strobe toggle and that the counter, not the address bus, picks the row. Seventeen counter refreshes check wrap-around order. Test mode is entered twice and left by each of the two exit paths, so an exit on the wrong cycle kind is seen.

// File: rtl/dsd_pkg.sv
// Shared types for the DRAM strobe decoder.
// Assumes: strobe vector bit order ras, cas, we, oe (index 0..3).
package dsd_pkg;
    localparam int NSTRB   = 4;
    localparam int IDX_RAS = 0;
    localparam int IDX_CAS = 1;
    localparam int IDX_WE  = 2;
    localparam int IDX_OE  = 3;

    typedef enum logic [2:0] {
        K_IDLE     = 3'd0,
        K_READ     = 3'd1,
        K_EARLY    = 3'd2,
        K_LATE     = 3'd3,
        K_RAS_ONLY = 3'd4,
        K_CBR      = 3'd5,
        K_HIDDEN   = 3'd6,
        K_TEST     = 3'd7
    } cyc_kind_e;
endpackage

// File: rtl/dsd_strobe_sync.sv
// Two-flop synchroniser bank for active-low asynchronous strobes.
// Output lo[i] is 1 when strobe i is asserted (low) after two clocks.
// Assumes: reset state is "all strobes inactive".
module dsd_strobe_sync #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_n,
    output logic [N-1:0] lo
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic meta_q, sync_q;
        // two-stage capture of one strobe pin
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b1;
                sync_q <= 1'b1;
            end else begin
                meta_q <= raw_n[i];
                sync_q <= meta_q;
            end
        end
        assign lo[i] = ~sync_q;
    end
endmodule

// File: rtl/dsd_refresh_ctr.sv
// Internal refresh row counter used by counter-addressed refresh.
// Assumes: step is a single-cycle pulse, wraps modulo 2^W.
module dsd_refresh_ctr #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] row
);
    // advance once per counter refresh
    always_ff @(posedge clk) begin
        if (!rst_n)    row <= '0;
        else if (step) row <= row + 1'b1;
    end
endmodule

// File: rtl/dsd_ctrl.sv
// Cycle classifier and datapath: row/column latching, read capture,
// early/late write detection, refresh reporting and test mode.
// Assumes: synchronised active-high strobe levels; addr/din stable
// when a strobe edge is acted on.
module dsd_ctrl
    import dsd_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSTRB-1:0] lo,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    din,
    input  logic [AW-1:0]    ctr_row,
    output logic             ctr_step,
    output logic [AW-1:0]    arr_row,
    output logic [AW-1:0]    arr_col,
    output logic             arr_we,
    output logic [DW-1:0]    arr_wdata,
    input  logic [DW-1:0]    arr_rdata,
    output logic [DW-1:0]    dq_out,
    output logic             dq_oe,
    output logic             refresh_valid,
    output logic [AW-1:0]    refresh_row,
    output logic             test_mode,
    output cyc_kind_e        cyc_kind,
    output logic             oe_err
);
    localparam int NE = IDX_WE + 1;   // strobes needing edge detection

    logic [NE-1:0] prev_lo;
    logic ras_lo, cas_lo, we_lo, oe_lo;
    logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
    logic active_q, cas_seen_q, rd_pend_q, data_valid_q;
    logic [DW-1:0] data_q;

    assign ras_lo = lo[IDX_RAS];
    assign cas_lo = lo[IDX_CAS];
    assign we_lo  = lo[IDX_WE];
    assign oe_lo  = lo[IDX_OE];

    // edge history of the three edge-sensitive strobes
    always_ff @(posedge clk) begin
        if (!rst_n) prev_lo <= '0;
        else        prev_lo <= lo[NE-1:0];
    end

    assign ras_fall = ras_lo & ~prev_lo[IDX_RAS];
    assign ras_rise = ~ras_lo & prev_lo[IDX_RAS];
    assign cas_fall = cas_lo & ~prev_lo[IDX_CAS];
    assign cas_rise = ~cas_lo & prev_lo[IDX_CAS];
    assign we_fall  = we_lo & ~prev_lo[IDX_WE];

    // counter refresh whenever the row strobe falls under a low column strobe
    assign ctr_step = ras_fall & cas_lo;

    // output drive: held read data, column strobe and output enable low
    assign dq_oe  = data_valid_q & cas_lo & oe_lo;
    assign dq_out = data_q;

    // main cycle sequencing and classification
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_row       <= '0;
            arr_col       <= '0;
            arr_we        <= 1'b0;
            arr_wdata     <= '0;
            active_q      <= 1'b0;
            cas_seen_q    <= 1'b0;
            rd_pend_q     <= 1'b0;
            data_valid_q  <= 1'b0;
            data_q        <= '0;
            refresh_valid <= 1'b0;
            refresh_row   <= '0;
            test_mode     <= 1'b0;
            cyc_kind      <= K_IDLE;
            oe_err        <= 1'b0;
        end else begin
            arr_we        <= 1'b0;
            refresh_valid <= 1'b0;
            oe_err        <= 1'b0;

            if (rd_pend_q) begin
                data_q       <= arr_rdata;
                data_valid_q <= 1'b1;
                rd_pend_q    <= 1'b0;
            end
            if (cas_rise) begin
                data_valid_q <= 1'b0;
            end

            if (ras_fall) begin
                if (cas_lo) begin
                    refresh_valid <= 1'b1;
                    refresh_row   <= ctr_row;
                    if (we_lo) begin
                        test_mode <= 1'b1;
                        cyc_kind  <= K_TEST;
                    end else begin
                        test_mode <= 1'b0;
                        cyc_kind  <= data_valid_q ? K_HIDDEN : K_CBR;
                    end
                end else begin
                    arr_row    <= addr;
                    active_q   <= 1'b1;
                    cas_seen_q <= 1'b0;
                end
            end

            if (ras_rise) begin
                if (active_q && !cas_seen_q) begin
                    refresh_valid <= 1'b1;
                    refresh_row   <= arr_row;
                    test_mode     <= 1'b0;
                    cyc_kind      <= K_RAS_ONLY;
                end
                active_q <= 1'b0;
            end

            if (cas_fall && active_q && ras_lo) begin
                arr_col    <= addr;
                cas_seen_q <= 1'b1;
                if (we_lo) begin
                    arr_we    <= 1'b1;
                    arr_wdata <= din;
                    cyc_kind  <= K_EARLY;
                end else begin
                    rd_pend_q <= 1'b1;
                    cyc_kind  <= K_READ;
                end
            end

            if (we_fall && active_q && cas_lo && data_valid_q) begin
                if (oe_lo) begin
                    oe_err <= 1'b1;
                end else begin
                    arr_we    <= 1'b1;
                    arr_wdata <= din;
                    cyc_kind  <= K_LATE;
                end
            end
        end
    end
endmodule

// File: rtl/dram_strobe_ctl.sv
// Top: synchronises the four strobes, runs the cycle classifier and
// owns the refresh counter.
// Assumes: the array answers arr_rdata combinationally.
module dram_strobe_ctl #(
    parameter int AW = 10,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    output logic [AW-1:0] arr_row,
    output logic [AW-1:0] arr_col,
    output logic          arr_we,
    output logic [DW-1:0] arr_wdata,
    input  logic [DW-1:0] arr_rdata,
    output logic          refresh_valid,
    output logic [AW-1:0] refresh_row,
    output logic          test_mode,
    output logic [2:0]    cyc_kind,
    output logic          oe_err
);
    import dsd_pkg::*;

    logic [NSTRB-1:0] strb_lo;
    logic [AW-1:0]    ctr_row;
    logic             ctr_step;
    cyc_kind_e        kind;

    dsd_strobe_sync #(.N(NSTRB)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_n ({oe_n, we_n, cas_n, ras_n}),
        .lo    (strb_lo)
    );

    dsd_refresh_ctr #(.W(AW)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (ctr_step),
        .row   (ctr_row)
    );

    dsd_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .lo            (strb_lo),
        .addr          (addr),
        .din           (din),
        .ctr_row       (ctr_row),
        .ctr_step      (ctr_step),
        .arr_row       (arr_row),
        .arr_col       (arr_col),
        .arr_we        (arr_we),
        .arr_wdata     (arr_wdata),
        .arr_rdata     (arr_rdata),
        .dq_out        (dq_out),
        .dq_oe         (dq_oe),
        .refresh_valid (refresh_valid),
        .refresh_row   (refresh_row),
        .test_mode     (test_mode),
        .cyc_kind      (kind),
        .oe_err        (oe_err)
    );

    assign cyc_kind = kind;
endmodule

// File: rtl/dsd_checker.sv
// Temporal checks for dram_strobe_ctl, attached by bind below.
// Assumes: observes top ports plus the internal counter row and step.
module dsd_checker
    import dsd_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    cyc_kind,
    input logic          dq_oe,
    input logic [DW-1:0] dq_out,
    input logic          arr_we,
    input logic          oe_err,
    input logic          refresh_valid,
    input logic [AW-1:0] refresh_row,
    input logic          test_mode,
    input logic [AW-1:0] ctr_row,
    input logic          ctr_step
);
    // R9: a counter refresh reports the old count and steps it by one
    p_ctr_refresh_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_step |=> refresh_valid && (refresh_row == $past(ctr_row))
                     && (ctr_row == AW'($past(ctr_row) + 1'b1)));

    // R3: an early write never drives the data pins
    p_early_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind == K_EARLY) |-> !dq_oe);

    // R4: array writes leave the presented read word untouched
    p_write_keeps_dq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> $stable(dq_out));

    // R5: a refused late write produces no array write
    p_err_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        oe_err |-> !arr_we);

    // R11: a RAS-only refresh leaves test mode
    p_rasonly_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_valid && cyc_kind == K_RAS_ONLY) |-> !test_mode);

    // R11: a counter refresh with write enable low is in test mode
    p_test_entry_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_valid && cyc_kind == K_TEST) |-> test_mode);
endmodule

bind dram_strobe_ctl dsd_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cyc_kind      (cyc_kind),
    .dq_oe         (dq_oe),
    .dq_out        (dq_out),
    .arr_we        (arr_we),
    .oe_err        (oe_err),
    .refresh_valid (refresh_valid),
    .refresh_row   (refresh_row),
    .test_mode     (test_mode),
    .ctr_row       (ctr_row),
    .ctr_step      (ctr_step)
);

// File: tb/sim_dram_strobe_ctl.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, small array model attached.
module sim_dram_strobe_ctl;
    localparam int AW = 4;
    localparam int DW = 4;
    localparam int S  = 6;   // settle clocks after a strobe change

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dq_out, arr_wdata, arr_rdata;
    logic dq_oe, arr_we, refresh_valid, test_mode, oe_err;
    logic [AW-1:0] arr_row, arr_col, refresh_row;
    logic [2:0] cyc_kind;

    int checks = 0, errors = 0;
    int ref_cnt = 0, err_cnt = 0;
    int last_ref_row = -1;
    int exp_ctr = 0;
    bit done = 1'b0;

    logic [DW-1:0] mem [0:(1<<(2*AW))-1];

    always #2.5 clk = ~clk;

    dram_strobe_ctl #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din),
        .dq_out(dq_out), .dq_oe(dq_oe), .arr_row(arr_row), .arr_col(arr_col),
        .arr_we(arr_we), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata),
        .refresh_valid(refresh_valid), .refresh_row(refresh_row),
        .test_mode(test_mode), .cyc_kind(cyc_kind), .oe_err(oe_err)
    );

    function automatic logic [DW-1:0] pat(input int idx);
        return DW'(idx * 7 + 3);
    endfunction

    // array model
    assign arr_rdata = mem[{arr_row, arr_col}];
    always @(posedge clk) if (arr_we) mem[{arr_row, arr_col}] <= arr_wdata;

    // pulse monitors, sampled on the falling edge
    always @(negedge clk) begin
        if (rst_n && refresh_valid) begin
            ref_cnt++;
            last_ref_row = int'(refresh_row);
        end
        if (rst_n && oe_err) err_cnt++;
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic open_row(input int row);
        addr = AW'(row); tick(1);
        ras_n = 1'b0; tick(S);
    endtask

    task automatic close_row();
        cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b0; tick(S);
        ras_n = 1'b1; tick(S);
    endtask

    task automatic cas_down(input int col);
        addr = AW'(col); tick(1);
        cas_n = 1'b0; tick(S);
    endtask

    task automatic t_reset();
        check("R1 dq_oe", int'(dq_oe), 0);
        check("R1 arr_we", int'(arr_we), 0);
        check("R1 refresh_valid", int'(refresh_valid), 0);
        check("R1 oe_err", int'(oe_err), 0);
        check("R1 test_mode", int'(test_mode), 0);
        check("R1 refresh_row", int'(refresh_row), 0);
        check("R1 cyc_kind", int'(cyc_kind), 0);
    endtask

    task automatic t_read(input int row, input int col, input int exp);
        open_row(row);
        cas_down(col);
        check("R2 dq_oe", int'(dq_oe), 1);
        check("R2 data", int'(dq_out), exp);
        check("R2 kind", int'(cyc_kind), 1);
        cas_n = 1'b1; tick(S);
        check("R6 hiz cas high", int'(dq_oe), 0);
        close_row();
    endtask

    task automatic t_early();
        open_row(2);
        din = 4'hA; we_n = 1'b0; tick(S);
        cas_down(5);
        check("R3 hiz", int'(dq_oe), 0);
        check("R3 kind", int'(cyc_kind), 2);
        tick(S);
        check("R3 hiz held", int'(dq_oe), 0);
        close_row();
        t_read(2, 5, 'hA);
    endtask

    task automatic t_late();
        int e0;
        e0 = err_cnt;
        open_row(3);
        cas_down(1);
        check("R4 read first", int'(dq_out), int'(pat(3*16+1)));
        oe_n = 1'b1; tick(S);
        check("R6 hiz oe high", int'(dq_oe), 0);
        din = 4'h5; we_n = 1'b0; tick(S);
        check("R4 kind", int'(cyc_kind), 3);
        check("R4 no err", err_cnt, e0);
        we_n = 1'b1; oe_n = 1'b0; tick(S);
        check("R4 dq_oe back", int'(dq_oe), 1);
        check("R4 old data held", int'(dq_out), int'(pat(3*16+1)));
        close_row();
        t_read(3, 1, 5);
    endtask

    task automatic t_late_oe_low();
        int e0;
        e0 = err_cnt;
        open_row(6);
        cas_down(2);
        din = 4'h9; we_n = 1'b0; tick(S);
        check("R5 err pulse", err_cnt, e0 + 1);
        check("R5 kind kept", int'(cyc_kind), 1);
        close_row();
        t_read(6, 2, int'(pat(6*16+2)));
    endtask

    task automatic t_page();
        open_row(4);
        for (int c = 0; c < 3; c++) begin
            cas_down(c);
            check("R7 page data", int'(dq_out), int'(pat(4*16+c)));
            cas_n = 1'b1; tick(S);
            check("R7 hiz between", int'(dq_oe), 0);
        end
        close_row();
    endtask

    task automatic ras_only(input int row);
        addr = AW'(row); tick(1);
        ras_n = 1'b0; tick(S);
        ras_n = 1'b1; tick(S);
    endtask

    task automatic t_ras_only();
        int r0;
        r0 = ref_cnt;
        ras_only(9);
        check("R8 pulse", ref_cnt, r0 + 1);
        check("R8 row", last_ref_row, 9);
        check("R8 kind", int'(cyc_kind), 4);
        check("R8 hiz", int'(dq_oe), 0);
    endtask

    task automatic cbr(input bit we_low);
        we_n = ~we_low; tick(1);
        cas_n = 1'b0; tick(S);
        ras_n = 1'b0; tick(S);
    endtask

    task automatic cbr_end();
        ras_n = 1'b1; tick(S);
        cas_n = 1'b1; we_n = 1'b1; tick(S);
    endtask

    task automatic t_cbr();
        for (int i = 0; i < 17; i++) begin
            int r0;
            r0 = ref_cnt;
            cbr(1'b0);
            check("R9 pulse", ref_cnt, r0 + 1);
            check("R9 counter row", last_ref_row, exp_ctr);
            check("R9 kind", int'(cyc_kind), 5);
            exp_ctr = (exp_ctr + 1) % (1 << AW);
            cbr_end();
        end
    endtask

    task automatic t_hidden();
        open_row(5);
        cas_down(6);
        ras_n = 1'b1; tick(S);
        check("R10 drive across ras high", int'(dq_oe), 1);
        ras_n = 1'b0; tick(S);
        check("R10 kind", int'(cyc_kind), 6);
        check("R10 counter row", last_ref_row, exp_ctr);
        check("R10 dq_oe", int'(dq_oe), 1);
        check("R10 data held", int'(dq_out), int'(pat(5*16+6)));
        exp_ctr = (exp_ctr + 1) % (1 << AW);
        cbr_end();
    endtask

    task automatic t_test_mode();
        cbr(1'b1);
        check("R11 enter", int'(test_mode), 1);
        check("R11 kind", int'(cyc_kind), 7);
        check("R11 refresh row", last_ref_row, exp_ctr);
        exp_ctr = (exp_ctr + 1) % (1 << AW);
        cbr_end();
        cbr(1'b1);
        check("R11 stays", int'(test_mode), 1);
        exp_ctr = (exp_ctr + 1) % (1 << AW);
        cbr_end();
        cbr(1'b0);
        check("R11 exit by cbr", int'(test_mode), 0);
        check("R11 counter after test", last_ref_row, exp_ctr);
        exp_ctr = (exp_ctr + 1) % (1 << AW);
        cbr_end();
        cbr(1'b1);
        check("R11 re-enter", int'(test_mode), 1);
        exp_ctr = (exp_ctr + 1) % (1 << AW);
        cbr_end();
        ras_only(3);
        check("R11 exit by ras-only", int'(test_mode), 0);
    endtask

    initial begin
        for (int i = 0; i < (1 << (2*AW)); i++) mem[i] = pat(i);
        tick(4);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_read(2, 3, int'(pat(2*16+3)));
        t_early();
        t_late();
        t_late_oe_low();
        t_page();
        t_ras_only();
        t_cbr();
        t_hidden();
        t_test_mode();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule